// File: doc/BRIEF.md
# Systolic Multi-Kernel 2D Convolver

This block computes the forward pass of one convolution layer over a single input plane. Several square kernels, `NKER` of them, each `KSZ`×`KSZ`, are first written one coefficient per cycle through a serial load port. The plane then streams in one pixel per accepted cycle, in raster order, with rows `IMG_W` pixels wide. Each accepted pixel is presented once to every tap of every kernel, so each step performs `NKER·KSZ²` multiplications in parallel.

Each kernel has its own chain of processing elements. Inside one kernel row, partial sums move from tap to tap. Between kernel rows they pass through a delay line `IMG_W−KSZ` steps long. The last tap of the last row therefore holds the finished window sum for the pixel that just entered. A frame-start flag marks the first pixel of each plane. An output strobe marks the steps whose window lies completely inside the plane. The design requires `IMG_W > KSZ ≥ 2`.

Operands are 8-bit signed values. Sums accumulate exactly in 24 bits. Each kernel lane clamps its result to a signed 16-bit value at the output.

Top module: `sys_conv2d`

## Requirements
- R1: After reset, `out_valid` is low, every output lane reads 0, every coefficient is 0, the load pointer is at the first coefficient, and the next pixel is taken as row 0, column 0.
- R2: Each cycle with `kload_valid` high writes `kload_data` to the next coefficient. Kernel 0 is written first. Within a kernel the order is row-major from the top-left tap (index = row·KSZ + col). After `NKER·KSZ²` transfers the pointer returns to kernel 0, tap 0.
- R3: Lane l is `out_data[16l+15:16l]`. For an accepted pixel at (r, c), lane l carries sum over i,j in [0,KSZ) of w_l[i][j]·x[r−KSZ+1+i][c−KSZ+1+j], and all lanes are updated in the same cycle.
- R4: `out_valid` is high for exactly one clock: the clock after the edge that accepts a pixel with row ≥ KSZ−1 and column ≥ KSZ−1. Row and column count from 0 at the frame start, and the column wraps to 0 after IMG_W−1. In every other cycle it is low.
- R5: A pixel in columns 0..KSZ−2 or rows 0..KSZ−2 never raises `out_valid`. Such windows would wrap past the row edge or reach above the plane.
- R6: A window sum above 32767 reads as 32767, and one below −32768 reads as −32768.
- R7: A cycle with `pix_valid` low changes no result. The lanes hold their value, and later results match a gap-free stream.
- R8: A pixel accepted with `pix_sof` high is row 0, column 0 of a new plane. No pixel before it contributes to any later valid result.
- R9: Pixels and coefficients are two's complement 8-bit values, and the sum is exact within 24 bits before clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| kload_valid | input | 1 | Coefficient write strobe |
| kload_data | input | 8 | Signed coefficient |
| pix_valid | input | 1 | Pixel accepted this cycle |
| pix_sof | input | 1 | Accepted pixel is the first of a plane |
| pix_data | input | 8 | Signed pixel |
| out_valid | output | 1 | Lanes hold a valid window result |
| out_data | output | NKER·16 | One clamped signed result per kernel |

## Verification
A plane that is zero except for a single unit pixel reproduces each kernel, mirrored, as the window slides across it. This separates a correct coefficient order from a transposed or shifted one. Pseudo-random signed planes with idle gaps exercise sign extension, stalls and both kernels together. A plane restarted part-way through a row shows whether stale rows or a stale column count leak into the new frame. Constant full-scale planes, paired with extreme kernels, drive both lanes into opposite clamps.

// File: rtl/sconv_pkg.sv
package sconv_pkg;
  localparam int PIX_W = 8;
  localparam int ACC_W = 24;
  localparam int RES_W = 16;

  typedef logic signed [PIX_W-1:0] pix_t;
  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [RES_W-1:0] res_t;

  localparam acc_t RES_MAX = acc_t'((1 << (RES_W - 1)) - 1);
  localparam acc_t RES_MIN = acc_t'(-(1 << (RES_W - 1)));

  // one multiply-accumulate step of a tap
  function automatic acc_t mac(input acc_t cin, input pix_t coef, input pix_t pix);
    acc_t prod;
    prod = acc_t'(coef) * acc_t'(pix);
    return cin + prod;
  endfunction

  // clamp a wide sum into the output range
  function automatic res_t clip(input acc_t a);
    if (a > RES_MAX) return res_t'(RES_MAX);
    if (a < RES_MIN) return res_t'(RES_MIN);
    return res_t'(a);
  endfunction
endpackage

// File: rtl/sconv_tap.sv
module sconv_tap
  import sconv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  pix_t coef,
  input  pix_t pix,
  input  acc_t cin,
  output acc_t psum
);
  always_ff @(posedge clk) begin
    if (!rst_n) psum <= '0;
    else if (step) psum <= mac(cin, coef, pix);
  end

  // R7: a tap only moves on an accepted pixel
  a_r7_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(psum));
endmodule

// File: rtl/sconv_linebuf.sv
module sconv_linebuf
  import sconv_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  acc_t din,
  output acc_t dout
);
  acc_t sr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
    end else if (step) begin
      sr[0] <= din;
      for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
    end
  end

  assign dout = sr[DEPTH-1];

  // R3: the row-to-row partial sum enters the delay only on a step
  a_r3_delay_shift: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> sr[0] == $past(din));
endmodule

// File: rtl/sconv_lane.sv
module sconv_lane
  import sconv_pkg::*;
#(
  parameter int KSZ   = 3,
  parameter int IMG_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  pix_t pix,
  input  pix_t coef [KSZ*KSZ],
  output acc_t result
);
  localparam int GAP = IMG_W - KSZ;

  acc_t chain    [KSZ][KSZ];
  acc_t row_feed [KSZ];

  for (genvar gi = 0; gi < KSZ; gi++) begin : g_row
    if (gi == 0) begin : g_head
      assign row_feed[gi] = '0;
    end else begin : g_delay
      sconv_linebuf #(.DEPTH(GAP)) u_lb (
        .clk  (clk),
        .rst_n(rst_n),
        .step (step),
        .din  (chain[gi-1][KSZ-1]),
        .dout (row_feed[gi])
      );
    end

    for (genvar gj = 0; gj < KSZ; gj++) begin : g_tap
      acc_t cin_w;
      if (gj == 0) begin : g_first
        assign cin_w = row_feed[gi];
      end else begin : g_next
        assign cin_w = chain[gi][gj-1];
      end
      sconv_tap u_tap (
        .clk  (clk),
        .rst_n(rst_n),
        .step (step),
        .coef (coef[gi*KSZ+gj]),
        .pix  (pix),
        .cin  (cin_w),
        .psum (chain[gi][gj])
      );
    end
  end

  assign result = chain[KSZ-1][KSZ-1];
endmodule

// File: rtl/sys_conv2d.sv
module sys_conv2d
  import sconv_pkg::*;
#(
  parameter int KSZ   = 3,
  parameter int NKER  = 2,
  parameter int IMG_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    kload_valid,
  input  logic [PIX_W-1:0]        kload_data,
  input  logic                    pix_valid,
  input  logic                    pix_sof,
  input  logic [PIX_W-1:0]        pix_data,
  output logic                    out_valid,
  output logic [NKER*RES_W-1:0]   out_data
);
  localparam int KK = KSZ * KSZ;
  localparam int TW = (KK > 1) ? $clog2(KK) : 1;
  localparam int KW = (NKER > 1) ? $clog2(NKER) : 1;
  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int RW = (KSZ > 1) ? $clog2(KSZ) : 1;

  localparam logic [TW-1:0] TAP_LAST = TW'(KK - 1);
  localparam logic [KW-1:0] KER_LAST = KW'(NKER - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
  localparam logic [CW-1:0] COL_FIRST_OK = CW'(KSZ - 1);
  localparam logic [RW-1:0] ROW_FULL = RW'(KSZ - 1);

  // ---------------- coefficient store ----------------
  logic [TW-1:0] tap_q;
  logic [KW-1:0] ker_q;
  pix_t          wgt [NKER][KK];
  logic          ld_last;

  assign ld_last = (tap_q == TAP_LAST) && (ker_q == KER_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q <= '0;
      ker_q <= '0;
      for (int l = 0; l < NKER; l++)
        for (int t = 0; t < KK; t++) wgt[l][t] <= '0;
    end else if (kload_valid) begin
      wgt[ker_q][tap_q] <= pix_t'(kload_data);
      if (tap_q == TAP_LAST) begin
        tap_q <= '0;
        ker_q <= ld_last ? '0 : ker_q + 1'b1;
      end else begin
        tap_q <= tap_q + 1'b1;
      end
    end
  end

  // ---------------- frame position ----------------
  logic [CW-1:0] col_q, cur_col;
  logic [RW-1:0] row_q, cur_row;
  logic          win_ok, row_end, step, valid_q;
  pix_t          pix_s;

  assign step    = pix_valid;
  assign pix_s   = pix_t'(pix_data);
  assign cur_col = pix_sof ? '0 : col_q;
  assign cur_row = pix_sof ? '0 : row_q;
  assign row_end = (cur_col == COL_LAST);
  assign win_ok  = (cur_row == ROW_FULL) && (cur_col >= COL_FIRST_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q   <= '0;
      row_q   <= '0;
      valid_q <= 1'b0;
    end else if (step) begin
      col_q   <= row_end ? '0 : cur_col + 1'b1;
      row_q   <= (row_end && cur_row != ROW_FULL) ? cur_row + 1'b1 : cur_row;
      valid_q <= win_ok;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;

  // ---------------- kernel lanes ----------------
  for (genvar gl = 0; gl < NKER; gl++) begin : g_lane
    pix_t lane_coef [KK];
    acc_t lane_res;
    for (genvar gt = 0; gt < KK; gt++) begin : g_c
      assign lane_coef[gt] = wgt[gl][gt];
    end
    sconv_lane #(.KSZ(KSZ), .IMG_W(IMG_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .pix   (pix_s),
      .coef  (lane_coef),
      .result(lane_res)
    );
    assign out_data[gl*RES_W +: RES_W] = clip(lane_res);
  end

  // ---------------- assertions ----------------
  // R4: a valid result only follows an accepted pixel
  a_r4_valid_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_valid));

  // R5: left-edge columns never produce a result
  a_r5_edge_col_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_sof && col_q < COL_FIRST_OK) |=> !out_valid);

  // R8: the first pixel of a plane never produces a result
  a_r8_sof_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_sof) |=> !out_valid);

  // R2: the load pointer wraps after the last coefficient
  a_r2_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (kload_valid && ld_last) |=> (tap_q == '0 && ker_q == '0));
endmodule

// File: tb/sys_conv2d_test.sv
module sys_conv2d_test;
  localparam int K  = 3;
  localparam int NK = 2;
  localparam int W  = 8;
  localparam int KK = K * K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kload_valid = 1'b0;
  logic [7:0] kload_data = '0;
  logic pix_valid = 1'b0;
  logic pix_sof = 1'b0;
  logic [7:0] pix_data = '0;
  logic out_valid;
  logic [NK*16-1:0] out_data;

  always #4 clk = ~clk;

  sys_conv2d #(.KSZ(K), .NKER(NK), .IMG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .kload_valid(kload_valid), .kload_data(kload_data),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_data(pix_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  int kw [NK][KK];
  int img [32][W];
  int mrow = 0, mcol = 0, lk = 0, lt = 0;
  bit exp_v = 0;
  int exp_d [NK];
  int prev_d [NK];
  int unsigned seed = 32'h1234_5678;

  task automatic chk(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[31:24]) - 128;
  endfunction

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int lane(int l);
    return int'($signed(out_data[l*16 +: 16]));
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit kv, int kd, bit v, bit s, int d, string dtag);
    string vtag;
    kload_valid = kv; kload_data = 8'(kd);
    pix_valid = v; pix_sof = s; pix_data = 8'(d);
    @(posedge clk);
    vtag = "R4";
    exp_v = 0;
    if (kv) begin
      kw[lk][lt] = kd;
      if (lt == KK - 1) begin lt = 0; lk = (lk == NK - 1) ? 0 : lk + 1; end
      else lt++;
    end
    if (v) begin
      if (s) begin mrow = 0; mcol = 0; vtag = "R8"; end
      img[mrow][mcol] = d;
      if (mcol < K - 1 || mrow < K - 1) vtag = (vtag == "R8") ? "R8" : "R5";
      exp_v = (mrow >= K - 1) && (mcol >= K - 1);
      if (exp_v)
        for (int l = 0; l < NK; l++) begin
          int acc = 0;
          for (int i = 0; i < K; i++)
            for (int j = 0; j < K; j++)
              acc += kw[l][i*K+j] * img[mrow-K+1+i][mcol-K+1+j];
          exp_d[l] = sat(acc);
        end
      if (mcol == W - 1) begin mcol = 0; mrow++; end else mcol++;
    end
    @(negedge clk);
    chk(vtag, out_valid == exp_v, int'(out_valid), int'(exp_v));
    if (exp_v)
      for (int l = 0; l < NK; l++) chk(dtag, lane(l) == exp_d[l], lane(l), exp_d[l]);
    if (!v)
      for (int l = 0; l < NK; l++) chk("R7", lane(l) == prev_d[l], lane(l), prev_d[l]);
    for (int l = 0; l < NK; l++) prev_d[l] = lane(l);
    kload_valid = 0; pix_valid = 0; pix_sof = 0;
  endtask

  task automatic load_kernels(int mode);
    for (int l = 0; l < NK; l++)
      for (int t = 0; t < KK; t++) begin
        int c;
        case (mode)
          0: c = (l == 0) ? t + 1 : -(t * 3) + 5;
          1: c = (l == 0) ? 127 : -128;
          default: c = rnd() / 8;
        endcase
        cyc(1'b1, c, 1'b0, 1'b0, 0, "R2");
      end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int l = 0; l < NK; l++) begin
      exp_d[l] = 0; prev_d[l] = 0;
      for (int t = 0; t < KK; t++) kw[l][t] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", out_valid == 1'b0, int'(out_valid), 0);
    for (int l = 0; l < NK; l++) chk("R1", lane(l) == 0, lane(l), 0);

    // R1: coefficients reset to zero, results all zero
    for (int p = 0; p < 4 * W; p++) cyc(1'b0, 0, 1'b1, p == 0, rnd(), "R1");

    // R2/R3: unit impulse reveals coefficient order
    load_kernels(0);
    for (int p = 0; p < 5 * W; p++) cyc(1'b0, 0, 1'b1, p == 0, (p == 2 * W + 3) ? 1 : 0, "R2");

    // R3/R7/R9: signed random plane with idle gaps
    for (int p = 0; p < 6 * W; p++) begin
      cyc(1'b0, 0, 1'b1, p == 0, rnd(), "R9");
      if (p % 5 == 2) cyc(1'b0, 0, 1'b0, 1'b0, 0, "R7");
    end

    // R8: restart mid-row
    for (int p = 0; p < W + 3; p++) cyc(1'b0, 0, 1'b1, p == 0, rnd(), "R8");
    for (int p = 0; p < 4 * W; p++) cyc(1'b0, 0, 1'b1, p == 0, rnd(), "R8");

    // R6: both clamp directions
    load_kernels(1);
    for (int p = 0; p < 4 * W; p++) cyc(1'b0, 0, 1'b1, p == 0, (p < 2 * W + 4) ? 127 : -128, "R6");

    // R2: pointer wrapped, reload and run again
    load_kernels(2);
    for (int p = 0; p < 5 * W; p++) cyc(1'b0, 0, 1'b1, p == 0, rnd(), "R3");
    cyc(1'b0, 0, 1'b0, 1'b0, 0, "R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule